// File: doc/BRIEF.md
# Two-Dimensional Block Parity Checker

This block guards a block of bytes with parity in two directions. Bytes arrive one per cycle on a valid/ready stream, and a last flag marks the final byte of each block. For every accepted byte the block returns a row parity bit over that byte's data bits. It also folds each byte into a column accumulator, which holds one parity bit per bit position. One cycle after the last byte it emits the finished column parity byte and clears the accumulator for the next block.

In check mode each byte arrives together with the row bit received for it. The received column byte arrives on its own port with the last beat. One cycle after the last beat the block reports several results: how many rows failed, which row failed first, and a mask of the failing columns. A single failing row that crosses a single failing column points at one flipped bit, and the block reports its row and bit position. Any other nonzero pattern is flagged as uncorrectable. This pattern includes two flips inside one byte, which row parity alone cannot see. A block longer than the allowed maximum raises a length error. The block does not correct the data.

Parity sense is a parameter: even parity by default, inverted for odd parity.

Top module: `grid_parity_chk`

## Requirements
- R1: Each accepted beat (`in_valid` and `in_ready` both high) gives `row_vld` high in the next cycle. `row_par` then equals the XOR of that beat's data bits (even parity, the default), or its inverse when odd parity is selected. This holds in both modes.
- R2: One cycle after a beat with `in_last` high, `col_vld` pulses and `col_par` bit k is the XOR of bit k of every byte in the block. The accumulator starts from zero in each new block, so a one-byte block returns that byte.
- R3: In check mode `rep_vld` pulses one cycle after the last beat. `fail_cols` is the computed column byte XOR `in_colpar`. `fail_rows` counts the beats whose computed row bit differs from `in_rowpar`. `first_row` is the 0-based index of the first such beat.
- R4: When exactly one row and exactly one column fail, and there is no length error, `single_err` is 1, `err_row` gives that row and `err_bit` gives the bit position (0 is the least significant bit).
- R5: `multi_err` is 1 for any other nonzero failure pattern. This includes two flips in one byte (zero failing rows, two failing columns) and two flips in one column. A clean block reports zeros with both flags low, and the two flags are never high together.
- R6: A block with more than MAX_BEATS (64) beats sets `len_err` in its report. It never reports `single_err`. Rows beyond the limit are not counted.
- R7: After reset `in_ready` is 1 and `row_vld`, `col_vld` and `rep_vld` are 0.
- R8: A block sent in generate mode (`mode_check` = 0) produces no `rep_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_check | input | 1 | 0 = generate, 1 = check; held for a whole block |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted when high with `in_valid` |
| in_data | input | DATA_W | Data byte |
| in_rowpar | input | 1 | Received row parity bit (check mode) |
| in_last | input | 1 | Marks the final beat of a block |
| in_colpar | input | DATA_W | Received column byte, sampled with the last beat |
| row_vld | output | 1 | Row parity bit valid |
| row_par | output | 1 | Row parity of the previous beat |
| col_vld | output | 1 | Column parity byte valid |
| col_par | output | DATA_W | Column parity of the finished block |
| rep_vld | output | 1 | Check report valid |
| fail_rows | output | CNT_W | Count of failing rows |
| first_row | output | IDX_W | Index of the first failing row |
| fail_cols | output | DATA_W | Mask of failing columns |
| single_err | output | 1 | One row and one column fail |
| err_row | output | IDX_W | Row of the located bit |
| err_bit | output | BIT_W | Bit position of the located bit |
| multi_err | output | 1 | Failure pattern that cannot be located |
| len_err | output | 1 | Block exceeded MAX_BEATS beats |

## Verification
The assertions assume that `mode_check` stays the same for every beat of a block and that `in_colpar` is meaningful only on the last beat. The bench drives whole blocks at a fixed mode and places the received column byte only on the closing beat. Row and column bits are computed from the clean bytes, and the injected flips are applied to the data only. This keeps every expected failure pattern a plain function of the flip positions. Blocks are separated by an idle cycle.

// File: rtl/gp_pkg.sv
package gp_pkg;
   typedef enum logic {
      GP_GEN   = 1'b0,
      GP_CHECK = 1'b1
   } gp_mode_e;

   function automatic int unsigned gp_bits_for(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/gp_bit_par.sv
module gp_bit_par #(
   parameter int unsigned W       = 8,
   parameter bit          ODD_PAR = 1'b0
) (
   input  logic [W-1:0] bits,
   output logic         par
);
   generate
      if (ODD_PAR) begin : g_odd
         assign par = ~(^bits);
      end else begin : g_even
         assign par = ^bits;
      end
   endgenerate
endmodule

// File: rtl/gp_col_acc.sv
module gp_col_acc #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         close,
   input  logic [W-1:0] d,
   output logic [W-1:0] acc_q,
   output logic [W-1:0] acc_next
);
   assign acc_next = acc_q ^ d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (en)      acc_q <= close ? '0 : acc_next;
   end
endmodule

// File: rtl/gp_locate.sv
module gp_locate #(
   parameter int unsigned W  = 8,
   parameter int unsigned BW = 3,
   parameter int unsigned CW = 4
) (
   input  logic [W-1:0]  mask,
   output logic [CW-1:0] ones,
   output logic [BW-1:0] pos
);
   always_comb begin
      ones = '0;
      pos  = '0;
      for (int i = 0; i < W; i++) begin
         if (mask[i]) begin
            ones = ones + 1'b1;
            pos  = BW'(i);
         end
      end
   end
endmodule

// File: rtl/grid_parity_chk.sv
module grid_parity_chk
   import gp_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_BEATS = 64,
   parameter bit          ODD_PAR   = 1'b0,
   localparam int unsigned IDX_W = gp_bits_for(MAX_BEATS),
   localparam int unsigned CNT_W = $clog2(MAX_BEATS + 1),
   localparam int unsigned BIT_W = gp_bits_for(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_check,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_rowpar,
   input  logic              in_last,
   input  logic [DATA_W-1:0] in_colpar,
   output logic              row_vld,
   output logic              row_par,
   output logic              col_vld,
   output logic [DATA_W-1:0] col_par,
   output logic              rep_vld,
   output logic [CNT_W-1:0]  fail_rows,
   output logic [IDX_W-1:0]  first_row,
   output logic [DATA_W-1:0] fail_cols,
   output logic              single_err,
   output logic [IDX_W-1:0]  err_row,
   output logic [BIT_W-1:0]  err_bit,
   output logic              multi_err,
   output logic              len_err
);
   localparam int unsigned ONES_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("grid_parity_chk: DATA_W must be at least 2");
      end
      if (MAX_BEATS < 1) begin : g_bad_depth
         $error("grid_parity_chk: MAX_BEATS must be at least 1");
      end
   endgenerate

   logic              beat;
   logic              row_calc;
   logic              row_bad;
   logic              over_now;
   logic              len_next;
   logic [CNT_W-1:0]  beat_cnt_q;
   logic [CNT_W-1:0]  fcnt_q, fcnt_next;
   logic [IDX_W-1:0]  first_q, first_next;
   logic              len_q;
   logic [DATA_W-1:0] acc_q, acc_next;
   logic [DATA_W-1:0] col_calc;
   logic [DATA_W-1:0] col_mask;
   logic [ONES_W-1:0] col_ones;
   logic [BIT_W-1:0]  col_pos;
   logic              single_next, multi_next;
   gp_mode_e          mode;

   assign mode = gp_mode_e'(mode_check);
   assign beat = in_valid & in_ready;

   gp_bit_par #(.W(DATA_W), .ODD_PAR(ODD_PAR)) u_row (
      .bits (in_data),
      .par  (row_calc)
   );

   gp_col_acc #(.W(DATA_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (beat),
      .close    (in_last),
      .d        (in_data),
      .acc_q    (acc_q),
      .acc_next (acc_next)
   );

   assign col_calc = acc_next ^ {DATA_W{ODD_PAR}};
   assign col_mask = col_calc ^ in_colpar;

   gp_locate #(.W(DATA_W), .BW(BIT_W), .CW(ONES_W)) u_loc (
      .mask (col_mask),
      .ones (col_ones),
      .pos  (col_pos)
   );

   always_comb begin
      over_now   = (beat_cnt_q == CNT_W'(MAX_BEATS));
      len_next   = len_q | over_now;
      row_bad    = (row_calc ^ in_rowpar) & ~over_now;
      fcnt_next  = fcnt_q + CNT_W'(row_bad);
      first_next = first_q;
      if (row_bad && (fcnt_q == '0))
         first_next = beat_cnt_q[IDX_W-1:0];
      single_next = (fcnt_next == CNT_W'(1)) && (col_ones == ONES_W'(1)) && !len_next;
      multi_next  = !single_next && ((fcnt_next != '0) || (col_mask != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_ready   <= 1'b0;
         beat_cnt_q <= '0;
         fcnt_q     <= '0;
         first_q    <= '0;
         len_q      <= 1'b0;
         row_vld    <= 1'b0;
         row_par    <= 1'b0;
         col_vld    <= 1'b0;
         col_par    <= '0;
         rep_vld    <= 1'b0;
         fail_rows  <= '0;
         first_row  <= '0;
         fail_cols  <= '0;
         single_err <= 1'b0;
         err_row    <= '0;
         err_bit    <= '0;
         multi_err  <= 1'b0;
         len_err    <= 1'b0;
      end else begin
         in_ready <= 1'b1;
         row_vld  <= beat;
         col_vld  <= beat & in_last;
         rep_vld  <= beat & in_last & (mode == GP_CHECK);
         if (beat) begin
            row_par <= row_calc;
            if (in_last) begin
               col_par    <= col_calc;
               beat_cnt_q <= '0;
               fcnt_q     <= '0;
               first_q    <= '0;
               len_q      <= 1'b0;
               if (mode == GP_CHECK) begin
                  fail_rows  <= fcnt_next;
                  first_row  <= first_next;
                  fail_cols  <= col_mask;
                  single_err <= single_next;
                  err_row    <= first_next;
                  err_bit    <= col_pos;
                  multi_err  <= multi_next;
                  len_err    <= len_next;
               end
            end else begin
               if (!over_now) beat_cnt_q <= beat_cnt_q + 1'b1;
               len_q <= len_next;
               if (mode == GP_CHECK) begin
                  fcnt_q  <= fcnt_next;
                  first_q <= first_next;
               end
            end
         end
      end
   end
endmodule

// File: rtl/grid_parity_chk_sva.sv
module grid_parity_chk_sva #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_BEATS = 64,
   localparam int unsigned CNT_W = $clog2(MAX_BEATS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_check,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_last,
   input logic              row_vld,
   input logic              col_vld,
   input logic              rep_vld,
   input logic [CNT_W-1:0]  fail_rows,
   input logic [DATA_W-1:0] fail_cols,
   input logic              single_err,
   input logic              multi_err,
   input logic              len_err
);
   AST_ROW_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> row_vld); // R1

   AST_COL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> col_vld); // R2

   AST_REPORT_ONLY_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last && mode_check) |=> rep_vld); // R3

   AST_SINGLE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_vld && single_err) |-> ((fail_rows == CNT_W'(1)) && ($countones(fail_cols) == 1) && !len_err)); // R4

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rep_vld |-> !(single_err && multi_err)); // R5

   AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_vld && (fail_rows == '0) && (fail_cols == '0)) |-> (!single_err && !multi_err)); // R5

   AST_LEN_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_vld && len_err) |-> !single_err); // R6

   AST_GEN_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last && !mode_check) |=> !rep_vld); // R8
endmodule

bind grid_parity_chk grid_parity_chk_sva #(.DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)) u_sva (.*);

// File: tb/grid_parity_chk_test.sv
`timescale 1ns/1ps
module grid_parity_chk_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_check = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_rowpar = 1'b0;
   logic       in_last = 1'b0;
   logic [7:0] in_colpar = '0;
   logic       row_vld, row_par, col_vld, rep_vld;
   logic [7:0] col_par, fail_cols;
   logic [6:0] fail_rows;
   logic [5:0] first_row, err_row;
   logic [2:0] err_bit;
   logic       single_err, multi_err, len_err;

   int errors = 0;
   int checks = 0;

   typedef struct {
      int       cnt;
      int       first;
      logic [7:0] mask;
      bit       single;
      int       ebit;
      bit       multi;
      bit       len;
   } rep_t;

   bit   row_q[$];
   logic [7:0] col_q[$];
   rep_t rep_q[$];

   always #4 clk = ~clk;

   grid_parity_chk uut (
      .clk(clk), .rst_n(rst_n), .mode_check(mode_check), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .in_rowpar(in_rowpar), .in_last(in_last),
      .in_colpar(in_colpar), .row_vld(row_vld), .row_par(row_par), .col_vld(col_vld),
      .col_par(col_par), .rep_vld(rep_vld), .fail_rows(fail_rows), .first_row(first_row),
      .fail_cols(fail_cols), .single_err(single_err), .err_row(err_row), .err_bit(err_bit),
      .multi_err(multi_err), .len_err(len_err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: sends a block, flips bits (ra,ba) and (rb,bb) in the data only
   task automatic run_block(input bit chk, input int n, input int ra, input int ba,
                            input int rb, input int bb);
      logic [7:0] clean, sent, fm, colc, colt, cm;
      rep_t r;
      colc = '0; colt = '0; cm = '0;
      r.cnt = 0; r.first = 0;
      for (int i = 0; i < n; i++) begin
         clean = 8'((i * 29 + n * 7 + 3) & 255);
         fm = '0;
         if (i == ra) fm[ba] = 1'b1;
         if (i == rb) fm[bb] = ~fm[bb];
         sent = clean ^ fm;
         colc ^= clean;
         colt ^= sent;
         cm ^= fm;
         if ((^fm) && i < 64) begin
            if (r.cnt == 0) r.first = i;
            r.cnt++;
         end
         row_q.push_back(^sent);
         @(negedge clk);
         mode_check = chk;
         in_valid   = 1'b1;
         in_data    = sent;
         in_rowpar  = ^clean;
         in_last    = (i == n - 1);
         in_colpar  = (i == n - 1) ? colc : 8'h00;
      end
      col_q.push_back(colt);
      if (chk) begin
         r.mask   = cm;
         r.len    = (n > 64);
         r.single = (r.cnt == 1) && ($countones(cm) == 1) && !r.len;
         r.ebit   = 0;
         for (int k = 0; k < 8; k++) if (cm[k]) r.ebit = k;
         r.multi  = !r.single && ((r.cnt != 0) || (cm != 0));
         rep_q.push_back(r);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (row_vld) begin
            if (row_q.size() == 0) check("R1", "unexpected row_vld", 1, 0);
            else check("R1", "row_par", row_par, row_q.pop_front());
         end
         if (col_vld) begin
            if (col_q.size() == 0) check("R2", "unexpected col_vld", 1, 0);
            else check("R2", "col_par", col_par, col_q.pop_front());
         end
         if (rep_vld) begin
            if (rep_q.size() == 0) check("R8", "report in generate mode", 1, 0);
            else begin
               rep_t e;
               e = rep_q.pop_front();
               check("R3", "fail_rows", fail_rows, e.cnt);
               if (e.cnt != 0) check("R3", "first_row", first_row, e.first);
               check("R3", "fail_cols", fail_cols, e.mask);
               check("R4", "single_err", single_err, e.single);
               if (e.single) begin
                  check("R4", "err_row", err_row, e.first);
                  check("R4", "err_bit", err_bit, e.ebit);
               end
               check("R5", "multi_err", multi_err, e.multi);
               check("R6", "len_err", len_err, e.len);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", "in_ready", in_ready, 1);
      check("R7", "row_vld", row_vld, 0);
      check("R7", "col_vld", col_vld, 0);
      check("R7", "rep_vld", rep_vld, 0);

      run_block(1'b0, 4, -1, 0, -1, 0);   // R1 R2 R8 generate
      run_block(1'b0, 1, -1, 0, -1, 0);   // R2 single-beat block
      run_block(1'b0, 3, -1, 0, -1, 0);   // R2 accumulator restart
      run_block(1'b1, 8, -1, 0, -1, 0);   // R3 clean check
      run_block(1'b1, 8, 2, 5, -1, 0);    // R4 single flip
      run_block(1'b1, 6, 0, 1, 0, 6);     // R5 two flips one byte
      run_block(1'b1, 7, 1, 3, 4, 7);     // R5 two rows two columns
      run_block(1'b1, 9, 3, 2, 5, 2);     // R5 two flips one column
      run_block(1'b1, 66, 10, 0, -1, 0);  // R6 over length
      run_block(1'b1, 64, 63, 7, -1, 0);  // R4 R6 full length boundary
      run_block(1'b0, 5, -1, 0, -1, 0);   // R8 generate after check

      repeat (4) @(negedge clk);
      check("R1", "rows left", row_q.size(), 0);
      check("R2", "columns left", col_q.size(), 0);
      check("R3", "reports left", rep_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule